// File: doc/BRIEF.md
# Round-Robin Monitor Sequencer

This block cycles through ten measurement slots in a fixed order: temperature first, then the seven voltage inputs, then the two fan inputs, and then back to temperature. For each slot it raises a request towards an external converter, presents the slot index, and waits for a one-cycle done pulse that carries the result. Each result is stored where a host can read it back. Voltage and fan results go into a small result RAM. The temperature result goes into a separate register.

Monitoring runs only while the start control is high and the clear control is low. While a host transaction is open, no storage write takes place. A result that completes during a transaction is parked in a single holding slot and written once the transaction closes. While that slot is occupied, the sequencer issues no further request. As a result, the host never sees a value change partway through an access. Reset does not clear the result storage, so its contents are undefined until the first write.

Top module: `monseq_top`

## Requirements
- R1: A new converter request is started only when start_i = 1 and int_clear_i = 0. With either condition false, no request begins.
- R2: Slots are visited in the order 0..9 and then wrap to 0. Slot 0 is temperature, slots 1..7 are voltage inputs 0..6, and slots 8..9 are fans 1..2. conv_chan_o carries the slot number while a request is outstanding.
- R3: conv_req_o stays high with an unchanged conv_chan_o until a cycle in which conv_done_i is high. It is low in the following cycle, so there is at least one idle cycle between slots.
- R4: Slot k (k = 1..9) is stored at host address BASE_ADDR + k - 1 (0x20..0x28 by default). Slot 0 is held in a separate register read at TEMP_ADDR (0x2F by default). Any other address reads as 0.
- R5: A host read returns the most recently stored result for the addressed slot. A result accepted while host_busy_i = 0 is readable from the next cycle on.
- R6: A result accepted while host_busy_i = 1 is held and written at the first clock edge at which host_busy_i = 0. It is readable in the cycle after that edge.
- R7: The stored values do not change at any clock edge at which host_busy_i = 1.
- R8: At most one result is held back at a time. While one is held, no new request is issued, so no held result is ever overwritten.
- R9: If monitoring is stopped while a request is outstanding, that slot still completes and its result is stored. The sequencer then idles, and it restarts at slot 0.
- R10: conv_done_i and conv_data_i are ignored while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Monitoring enable |
| int_clear_i | input | 1 | Clear control; when high, monitoring is held off |
| host_busy_i | input | 1 | High while a host transaction is open |
| host_addr_i | input | ADDR_W | Host read address |
| host_rdata_o | output | DATA_W | Stored result at host_addr_i |
| conv_req_o | output | 1 | Converter request outstanding |
| conv_chan_o | output | 4 | Slot index of the request |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | DATA_W | Converter result, valid with conv_done_i |

## Verification
The bench builds the block with its default parameters: 8-bit data and addresses, a RAM base of 0x20 and the temperature register at 0x2F. With these values it can sweep every mapped address plus the unmapped 0x29, and it watches several complete wraps of all ten slots. Converter latencies from zero to six cycles, long and short host-busy windows, a stop issued while a request is outstanding, and done pulses sent without a request together reach the deferral, the single holding slot and the restart at temperature.

// File: rtl/monseq_pkg.sv
package monseq_pkg;
  localparam int NUM_SLOTS = 10;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int RAM_DEPTH = NUM_SLOTS - 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/monseq_slot_ctrl.sv
module monseq_slot_ctrl
  import monseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              pend_busy_i,
  input  logic              conv_done_i,
  output logic              conv_req_o,
  output logic [SLOT_W-1:0] conv_chan_o,
  output logic              accept_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_en;

  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    slot_en  = 1'b0;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!run_i) begin
          slot_d  = '0;
          slot_en = 1'b1;
        end else if (!pend_busy_i) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (conv_done_i) begin
          accept_o = 1'b1;
          state_d  = ST_IDLE;
          slot_en  = 1'b1;
          slot_d   = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      if (slot_en) slot_q <= slot_d;
    end
  end

  assign conv_req_o  = (state_q == ST_WAIT);
  assign conv_chan_o = slot_q;

  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req_o) |-> $past(run_i)); // R1
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !conv_done_i) |=> (conv_req_o && $stable(conv_chan_o))); // R3
  AST_SLOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && conv_done_i) |=> !conv_req_o); // R3
  AST_NO_REQ_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req_o) |-> !$past(pend_busy_i)); // R8
endmodule

// File: rtl/monseq_defer.sv
module monseq_defer
  import monseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_busy_i,
  input  logic              accept_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pend_v_o,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              pend_v_q, pend_v_d;
  logic [SLOT_W-1:0] pend_slot_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              load_en, drain;

  always_comb begin
    drain    = pend_v_q && !host_busy_i;
    load_en  = accept_i && host_busy_i;
    pend_v_d = pend_v_q;
    if (drain)   pend_v_d = 1'b0;
    if (load_en) pend_v_d = 1'b1;
    wr_en_o   = drain || (accept_i && !host_busy_i);
    wr_slot_o = pend_v_q ? pend_slot_q : slot_i;
    wr_data_o = pend_v_q ? pend_data_q : data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v_q <= 1'b0;
    else        pend_v_q <= pend_v_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      pend_slot_q <= slot_i;
      pend_data_q <= data_i;
    end
  end

  assign pend_v_o = pend_v_q;

  AST_DEFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && host_busy_i) |=> pend_v_q); // R6
  AST_SINGLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> !pend_v_q); // R8
endmodule

// File: rtl/monseq_store.sv
module monseq_store
  import monseq_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] TEMP_ADDR = 'h2F
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int OFF_W = $clog2(RAM_DEPTH);
  localparam logic [ADDR_W-1:0] END_ADDR = BASE_ADDR + ADDR_W'(RAM_DEPTH);

  logic [DATA_W-1:0] ram_q [RAM_DEPTH];
  logic [DATA_W-1:0] temp_q;
  logic [ADDR_W-1:0] rd_off;

  always_ff @(posedge clk) begin
    if (wr_en_i && wr_slot_i == '0) temp_q <= wr_data_i;
  end

  for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en_i && wr_slot_i == SLOT_W'(g + 1)) ram_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_off = rd_addr_i - BASE_ADDR;
    if (rd_addr_i == TEMP_ADDR)
      rd_data_o = temp_q;
    else if (rd_addr_i >= BASE_ADDR && rd_addr_i < END_ADDR)
      rd_data_o = ram_q[rd_off[OFF_W-1:0]];
    else
      rd_data_o = '0;
  end
endmodule

// File: rtl/monseq_top.sv
module monseq_top
  import monseq_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] TEMP_ADDR = 'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              int_clear_i,
  input  logic              host_busy_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              conv_req_o,
  output logic [SLOT_W-1:0] conv_chan_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i
);
  logic rst_meta, rst_sync_n;
  logic run, accept, pend_v, wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [DATA_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign run = start_i && !int_clear_i;

  monseq_slot_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run_i       (run),
    .pend_busy_i (pend_v),
    .conv_done_i (conv_done_i),
    .conv_req_o  (conv_req_o),
    .conv_chan_o (conv_chan_o),
    .accept_o    (accept)
  );

  monseq_defer #(.DATA_W(DATA_W)) u_defer (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_busy_i (host_busy_i),
    .accept_i    (accept),
    .slot_i      (conv_chan_o),
    .data_i      (conv_data_i),
    .pend_v_o    (pend_v),
    .wr_en_o     (wr_en),
    .wr_slot_o   (wr_slot),
    .wr_data_o   (wr_data)
  );

  monseq_store #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .TEMP_ADDR (TEMP_ADDR)
  ) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_slot_i (wr_slot),
    .wr_data_i (wr_data),
    .rd_addr_i (host_addr_i),
    .rd_data_o (host_rdata_o)
  );

  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> !host_busy_i); // R7
endmodule

// File: tb/monseq_top_bench.sv
module monseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h20;
  localparam logic [7:0] TEMP = 8'h2F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, int_clear_i = 1'b0, host_busy_i = 1'b0;
  logic [7:0] host_addr_i = 8'h20;
  logic [7:0] host_rdata_o;
  logic       conv_req_o;
  logic [3:0] conv_chan_o;
  logic       conv_done_i = 1'b0;
  logic [7:0] conv_data_i = 8'h00;

  monseq_top u_monseq_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .int_clear_i(int_clear_i),
    .host_busy_i(host_busy_i), .host_addr_i(host_addr_i), .host_rdata_o(host_rdata_o),
    .conv_req_o(conv_req_o), .conv_chan_o(conv_chan_o),
    .conv_done_i(conv_done_i), .conv_data_i(conv_data_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    errors = 0, checks = 0, cycles = 0;
  string cur_tag = "R1";
  int    lat = 1, seq = 0, rcnt = 0, bcnt = 0, acnt = 0;
  bit    spur = 1'b0, busy_mode = 1'b0;

  // reference model
  int         m_state = 0, m_slot = 0;
  bit         m_pend = 1'b0;
  int         m_pslot = 0;
  logic [7:0] m_pdata = 8'h00;
  logic [7:0] exp_mem [10];
  bit         exp_vld [10];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int slot_of(input logic [7:0] a);
    if (a == TEMP) return 0;
    if (a >= BASE && a < BASE + 8'd9) return int'(a - BASE) + 1;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_slot = 0; m_pend = 1'b0;
      for (int i = 0; i < 10; i++) exp_vld[i] = 1'b0;
    end else begin
      bit run, old_pend;
      run = start_i && !int_clear_i;
      old_pend = m_pend;
      if (old_pend && !host_busy_i) begin
        exp_mem[m_pslot] = m_pdata; exp_vld[m_pslot] = 1'b1; m_pend = 1'b0;
      end
      if (m_state == 1) begin
        if (conv_done_i) begin
          if (host_busy_i) begin
            m_pend = 1'b1; m_pslot = m_slot; m_pdata = conv_data_i;
          end else begin
            exp_mem[m_slot] = conv_data_i; exp_vld[m_slot] = 1'b1;
          end
          m_slot  = (m_slot + 1) % 10;
          m_state = 0;
        end
      end else begin
        if (!run) m_slot = 0;
        else if (!old_pend) m_state = 1;
      end
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int s;
      chk(conv_req_o == (m_state == 1), {cur_tag, " R1 R3 R8 req"}, conv_req_o, m_state);
      if (m_state == 1)
        chk(conv_chan_o == 4'(m_slot), {cur_tag, " R2 chan"}, conv_chan_o, m_slot);
      s = slot_of(host_addr_i);
      if (s < 0)
        chk(host_rdata_o == 8'h00, {cur_tag, " R4 unmapped"}, host_rdata_o, 0);
      else if (exp_vld[s])
        chk(host_rdata_o == exp_mem[s], {cur_tag, " R5 R7 read"}, host_rdata_o, exp_mem[s]);
    end
  end

  // converter model
  always @(negedge clk) begin
    #1;
    if (conv_req_o) begin
      if (rcnt >= lat) begin
        conv_done_i = 1'b1;
        conv_data_i = 8'((seq * 37 + int'(conv_chan_o) * 5 + 3) & 255);
        seq++;
        rcnt = 0;
      end else begin
        conv_done_i = 1'b0;
        rcnt++;
      end
    end else begin
      rcnt = 0;
      conv_done_i = spur;
      conv_data_i = 8'hEE;
    end
  end

  // host background traffic
  always @(negedge clk) begin
    #2;
    acnt = (acnt + 1) % 11;
    host_addr_i = (acnt == 9) ? TEMP : ((acnt == 10) ? 8'h29 : BASE + 8'(acnt));
    bcnt = (bcnt + 1) % 13;
    host_busy_i = busy_mode && (bcnt < 8);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    cur_tag = "R1";                       // reset state, no request
    wait_cyc(8);
    start_i = 1'b1; int_clear_i = 1'b1;   // clear held high: still off
    wait_cyc(12);
    int_clear_i = 1'b0;
    cur_tag = "R2 R4 R5";                 // free running, varied latency
    for (int r = 0; r < 4; r++) begin
      lat = r;
      wait_cyc(60);
    end
    cur_tag = "R6 R7 R8";                 // host busy windows
    busy_mode = 1'b1;
    for (int r = 0; r < 3; r++) begin
      lat = r * 2;
      wait_cyc(120);
    end
    busy_mode = 1'b0;
    wait_cyc(20);
    cur_tag = "R9";                       // stop mid-slot
    lat = 6;
    for (int r = 0; r < 3; r++) begin
      while (!conv_req_o || conv_chan_o != 4'(3 + r)) @(negedge clk);
      #3;
      start_i = 1'b0;
      wait_cyc(20);
      start_i = 1'b1;
      wait_cyc(40);
    end
    cur_tag = "R10";                      // done pulses without a request
    spur = 1'b1;
    start_i = 1'b0;
    wait_cyc(25);
    start_i = 1'b1;
    lat = 2;
    busy_mode = 1'b1;
    wait_cyc(150);
    busy_mode = 1'b0;
    spur = 1'b0;
    wait_cyc(30);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule